// File: doc/BRIEF.md
# Integer-N PLL Dividers with Status Pin Multiplexer

This block holds the digital dividers in front of the phase comparator of an integer-N synthesizer. A 12-bit reference divider runs on the reference clock and an 18-bit feedback divider runs on the feedback clock. Each divider emits a strobe one input clock wide once per programmed count. Each divider also keeps a square wave at half the strobe rate with 50% duty. Each divider takes a new divide value only when it wraps, so a change never produces a short period. A divide value of zero is illegal. A divider that sees zero stops and raises an error flag until a legal value returns.

A 4-bit selector drives a status pin. The pin can be off (high impedance), tied high or low, or show a digital lock flag in either polarity. It can also show an externally computed analog lock flag as push-pull or as either open-drain style, or show one of the two half-rate divider waves. The block reports the value and the output enable separately, so an open-drain mode appears as a change of the enable.

The block also produces a tick for the digital lock comparison. By default this is one tick per reference strobe. An option divides the tick rate by four for fast comparison rates.

Top module: `pll_div_stat`

## Requirements
- R1: After reset the reference divider uses a divide value of 10 whatever its input holds. `ref_pulse` is high for exactly one reference clock, on the N-th rising edge after the previous strobe (or after reset). N is the value in force, and the input value is captured at each strobe for the next interval.
- R2: The feedback divider behaves as in R1 on `fb_clk`, with 18-bit values and a reset divide value of 760.
- R3: `ref_half` and `fb_half` reset to 0 and toggle on exactly the rising edges at which their divider's strobe goes or stays high, and at no other edge.
- R4: When a divider captures a divide value of 0, its error flag is high from the next edge and it gives no strobes and holds its half wave. It samples its input every clock while stopped. The edge that sees a nonzero value V clears the flag, and the first strobe follows V edges later.
- R5: Selector codes 0, 8, 10 and 12 to 15 give `stat_oe`=0 and `stat_pin`=0.
- R6: Code 1 drives the pin high and code 2 drives it low, with `stat_oe`=1.
- R7: Code 3 drives `dig_lock` onto the pin and code 4 drives its inverse, with `stat_oe`=1.
- R8: Code 5 drives `ana_lock` push-pull. Code 6 is the pull-down style: `stat_pin`=0 and `stat_oe`=NOT `ana_lock`. Code 7 is the pull-up style: `stat_pin`=1 and `stat_oe`=`ana_lock`.
- R9: Code 9 drives `fb_half` and code 11 drives `ref_half` onto the pin, with `stat_oe`=1.
- R10: `lock_tick` is a one-clock pulse in the reference domain, one edge after a reference strobe. With `lock_div4`=0 every strobe makes a tick. With `lock_div4`=1 only the 4th, 8th, 12th… strobe since reset makes one (strobes are counted whatever the option is).
- R11: During reset all strobes, half waves, error flags and `lock_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| fb_clk | input | 1 | Feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| ref_div | input | 12 | Reference divide value, 1..4095 legal |
| fb_div | input | 18 | Feedback divide value, 1..262143 legal |
| pin_sel | input | 4 | Status pin selector code |
| dig_lock | input | 1 | Digital lock flag from outside |
| ana_lock | input | 1 | Analog lock flag from outside |
| lock_div4 | input | 1 | Divide the lock comparison tick by four |
| ref_pulse | output | 1 | Reference divider strobe |
| ref_half | output | 1 | Reference half-rate square wave |
| ref_err | output | 1 | Reference divide value is zero |
| fb_pulse | output | 1 | Feedback divider strobe |
| fb_half | output | 1 | Feedback half-rate square wave |
| fb_err | output | 1 | Feedback divide value is zero |
| lock_tick | output | 1 | Lock comparison tick (reference domain) |
| stat_pin | output | 1 | Status pin value |
| stat_oe | output | 1 | Status pin output enable |

## Verification
The bench goes after the reset divide values. Inputs are held at other values after reset, so a divider that loads its input at once shows its first strobe at the wrong edge. It changes divide values at random points, including 1 and 0. A divider that takes a new value in mid-count would give a short period, and one that wraps on zero would strobe while its error flag is high. It toggles the divide-by-four option in mid-run to catch a tick counter that restarts or counts only while the option is set. It sweeps every selector code against both lock flag levels, which exposes swapped open-drain polarities and invalid codes that drive the pin.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

   typedef enum logic [3:0] {
      STS_OFF      = 4'd0,
      STS_HIGH     = 4'd1,
      STS_LOW      = 4'd2,
      STS_DLK_POS  = 4'd3,
      STS_DLK_NEG  = 4'd4,
      STS_ALK_PP   = 4'd5,
      STS_ALK_PDN  = 4'd6,
      STS_ALK_PUP  = 4'd7,
      STS_FB_HALF  = 4'd9,
      STS_REF_HALF = 4'd11
   } sts_code_e;

   typedef struct packed {
      logic oe;
      logic val;
   } pin_drive_t;

   function automatic logic sts_code_valid(input logic [3:0] code);
      return (code <= 4'd7) || (code == 4'd9) || (code == 4'd11);
   endfunction

endpackage

// File: rtl/pll_int_div.sv
module pll_int_div #(
   parameter int W       = 12,
   parameter int RST_DIV = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] div_i,
   output logic         pulse_o,
   output logic         half_o,
   output logic         err_o
);

   if (W < 1 || W > 31) begin : g_bad_width
      $error("pll_int_div: W out of range");
   end
   if (RST_DIV < 1 || longint'(RST_DIV) >= (longint'(1) << W)) begin : g_bad_reset
      $error("pll_int_div: RST_DIV does not fit W");
   end

   localparam logic [W-1:0] RST_V = W'(RST_DIV);

   logic [W-1:0] per_q;
   logic [W-1:0] cnt_q;
   logic         pls_q;
   logic         half_q;
   logic         idle;
   logic         wrap;

   assign idle = (per_q == '0);
   assign wrap = !idle && (cnt_q == per_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= RST_V;
         cnt_q  <= '0;
         pls_q  <= 1'b0;
         half_q <= 1'b0;
      end else if (idle) begin
         per_q  <= div_i;
         cnt_q  <= '0;
         pls_q  <= 1'b0;
      end else if (wrap) begin
         per_q  <= div_i;
         cnt_q  <= '0;
         pls_q  <= 1'b1;
         half_q <= ~half_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         pls_q  <= 1'b0;
      end
   end

   assign pulse_o = pls_q;
   assign half_o  = half_q;
   assign err_o   = idle;

   // R1 / R2: with an interval of at least two, a strobe is one clock wide
   assert_pulse_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pls_q && per_q != 1) |=> !pls_q);

   // R3: the half wave changes exactly when a strobe is raised
   assert_half_tracks_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (half_q != $past(half_q)) == pls_q);

   // R4: a stopped divider stays silent and frozen
   assert_idle_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (!pulse_o && $stable(half_o)));

endmodule

// File: rtl/pll_lock_tick.sv
module pll_lock_tick #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic div_en_i,
   output logic tick_o
);

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("pll_lock_tick: PRESCALE must be at least 2");
   end

   localparam int QW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [QW-1:0] LAST = QW'(PRESCALE - 1);

   logic [QW-1:0] q_q;
   logic          tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= pulse_i && (!div_en_i || q_q == LAST);
         if (pulse_i) begin
            q_q <= (q_q == LAST) ? '0 : q_q + 1'b1;
         end
      end
   end

   assign tick_o = tick_q;

   // R10: a tick only ever follows a strobe by one clock
   assert_tick_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(pulse_i));

   // R10: with the option clear, every strobe makes a tick
   assert_tick_every_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && !div_en_i) |=> tick_o);

endmodule

// File: rtl/pll_stat_mux.sv
module pll_stat_mux
   import pll_div_pkg::*;
(
   input  logic [3:0] sel_i,
   input  logic       dlock_i,
   input  logic       alock_i,
   input  logic       fb_half_i,
   input  logic       ref_half_i,
   output logic       pin_o,
   output logic       oe_o
);

   pin_drive_t drv;

   always_comb begin
      drv = '{oe: 1'b0, val: 1'b0};
      if (sts_code_valid(sel_i)) begin
         case (sel_i)
            STS_HIGH:     drv = '{oe: 1'b1, val: 1'b1};
            STS_LOW:      drv = '{oe: 1'b1, val: 1'b0};
            STS_DLK_POS:  drv = '{oe: 1'b1, val: dlock_i};
            STS_DLK_NEG:  drv = '{oe: 1'b1, val: ~dlock_i};
            STS_ALK_PP:   drv = '{oe: 1'b1, val: alock_i};
            STS_ALK_PDN:  drv = '{oe: ~alock_i, val: 1'b0};
            STS_ALK_PUP:  drv = '{oe: alock_i, val: 1'b1};
            STS_FB_HALF:  drv = '{oe: 1'b1, val: fb_half_i};
            STS_REF_HALF: drv = '{oe: 1'b1, val: ref_half_i};
            default:      drv = '{oe: 1'b0, val: 1'b0};
         endcase
      end
   end

   assign pin_o = drv.val;
   assign oe_o  = drv.oe;

endmodule

// File: rtl/pll_div_stat.sv
module pll_div_stat
   import pll_div_pkg::*;
#(
   parameter int REF_W         = 12,
   parameter int FB_W          = 18,
   parameter int REF_RST       = 10,
   parameter int FB_RST        = 760,
   parameter int LOCK_PRESCALE = 4
) (
   input  logic             ref_clk,
   input  logic             fb_clk,
   input  logic             rst_n,
   input  logic [REF_W-1:0] ref_div,
   input  logic [FB_W-1:0]  fb_div,
   input  logic [3:0]       pin_sel,
   input  logic             dig_lock,
   input  logic             ana_lock,
   input  logic             lock_div4,
   output logic             ref_pulse,
   output logic             ref_half,
   output logic             ref_err,
   output logic             fb_pulse,
   output logic             fb_half,
   output logic             fb_err,
   output logic             lock_tick,
   output logic             stat_pin,
   output logic             stat_oe
);

   pll_int_div #(.W(REF_W), .RST_DIV(REF_RST)) u_ref_div (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .div_i   (ref_div),
      .pulse_o (ref_pulse),
      .half_o  (ref_half),
      .err_o   (ref_err)
   );

   pll_int_div #(.W(FB_W), .RST_DIV(FB_RST)) u_fb_div (
      .clk     (fb_clk),
      .rst_n   (rst_n),
      .div_i   (fb_div),
      .pulse_o (fb_pulse),
      .half_o  (fb_half),
      .err_o   (fb_err)
   );

   pll_lock_tick #(.PRESCALE(LOCK_PRESCALE)) u_lock_tick (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .pulse_i  (ref_pulse),
      .div_en_i (lock_div4),
      .tick_o   (lock_tick)
   );

   pll_stat_mux u_stat_mux (
      .sel_i      (pin_sel),
      .dlock_i    (dig_lock),
      .alock_i    (ana_lock),
      .fb_half_i  (fb_half),
      .ref_half_i (ref_half),
      .pin_o      (stat_pin),
      .oe_o       (stat_oe)
   );

   // R5: undefined codes and code 0 never drive the pin
   assert_off_codes_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!sts_code_valid(pin_sel) || pin_sel == 4'd0) |-> (!stat_oe && !stat_pin));

   // R6: code 1 is a driven high
   assert_drive_high_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (pin_sel == 4'd1) |-> (stat_oe && stat_pin));

   // R8: the pull-down style never presents a high value
   assert_pulldown_low_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (pin_sel == 4'd6) |-> !stat_pin);

   // R9: half-wave codes always drive
   assert_half_codes_drive_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (pin_sel == 4'd9 || pin_sel == 4'd11) |-> stat_oe);

endmodule

// File: tb/pll_div_stat_bench.sv
module pll_div_stat_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic        ref_clk = 1'b0;
   logic        fb_clk  = 1'b0;
   logic        rst_n;
   logic [11:0] ref_div;
   logic [17:0] fb_div;
   logic [3:0]  pin_sel;
   logic        dig_lock, ana_lock, lock_div4;
   logic        ref_pulse, ref_half, ref_err;
   logic        fb_pulse, fb_half, fb_err;
   logic        lock_tick, stat_pin, stat_oe;

   int  nchk = 0;
   int  nerr = 0;
   bit  ref_done = 0;
   bit  fb_done  = 0;
   bit  reported = 0;

   always #4 ref_clk = ~ref_clk;
   always #5 fb_clk  = ~fb_clk;

   pll_div_stat u_pll_div_stat (
      .ref_clk(ref_clk), .fb_clk(fb_clk), .rst_n(rst_n),
      .ref_div(ref_div), .fb_div(fb_div), .pin_sel(pin_sel),
      .dig_lock(dig_lock), .ana_lock(ana_lock), .lock_div4(lock_div4),
      .ref_pulse(ref_pulse), .ref_half(ref_half), .ref_err(ref_err),
      .fb_pulse(fb_pulse), .fb_half(fb_half), .fb_err(fb_err),
      .lock_tick(lock_tick), .stat_pin(stat_pin), .stat_oe(stat_oe)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      end
   endtask

   // expected pin drive {oe,val} per selector code
   function automatic logic [1:0] exp_pin(input int code, input bit dl, input bit al,
                                          input bit nh, input bit rh);
      case (code)
         1:  return 2'b11;
         2:  return 2'b10;
         3:  return {1'b1, dl};
         4:  return {1'b1, ~dl};
         5:  return {1'b1, al};
         6:  return {~al, 1'b0};
         7:  return {al, 1'b1};
         9:  return {1'b1, nh};
         11: return {1'b1, rh};
         default: return 2'b00;
      endcase
   endfunction

   function automatic string req_of(input int code);
      if (code == 1 || code == 2) return "R6";
      if (code == 3 || code == 4) return "R7";
      if (code >= 5 && code <= 7) return "R8";
      if (code == 9 || code == 11) return "R9";
      return "R5";
   endfunction

   // reference-domain expectation: interval in force, edges since restart
   int m_rlen, m_rgap, m_rcount;
   bit m_rpulse, m_rhalf, m_tick;
   always @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rlen = 10; m_rgap = 0; m_rcount = 0;
         m_rpulse = 0; m_rhalf = 0; m_tick = 0;
      end else begin
         if (m_rpulse) m_rcount++;
         m_tick = m_rpulse && (!lock_div4 || (m_rcount % 4 == 0));
         if (m_rlen == 0) begin
            m_rpulse = 0; m_rgap = 0; m_rlen = int'(ref_div);
         end else begin
            m_rgap++;
            m_rpulse = (m_rgap == m_rlen);
            if (m_rpulse) begin
               m_rhalf = ~m_rhalf; m_rgap = 0; m_rlen = int'(ref_div);
            end
         end
      end
   end

   always @(negedge ref_clk) begin
      if (rst_n === 1'b1) begin
         chk(ref_pulse == m_rpulse, "R1", "ref_pulse", ref_pulse, m_rpulse);
         chk(ref_half == m_rhalf, "R3", "ref_half", ref_half, m_rhalf);
         chk(ref_err == (m_rlen == 0), "R4", "ref_err", ref_err, m_rlen == 0);
         chk(lock_tick == m_tick, "R10", "lock_tick", lock_tick, m_tick);
      end
   end

   // feedback-domain expectation
   int m_flen, m_fgap;
   bit m_fpulse, m_fhalf;
   always @(posedge fb_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_flen = 760; m_fgap = 0; m_fpulse = 0; m_fhalf = 0;
      end else if (m_flen == 0) begin
         m_fpulse = 0; m_fgap = 0; m_flen = int'(fb_div);
      end else begin
         m_fgap++;
         m_fpulse = (m_fgap == m_flen);
         if (m_fpulse) begin
            m_fhalf = ~m_fhalf; m_fgap = 0; m_flen = int'(fb_div);
         end
      end
   end

   always @(negedge fb_clk) begin
      if (rst_n === 1'b1) begin
         chk(fb_pulse == m_fpulse, "R2", "fb_pulse", fb_pulse, m_fpulse);
         chk(fb_half == m_fhalf, "R3", "fb_half", fb_half, m_fhalf);
         chk(fb_err == (m_flen == 0), "R4", "fb_err", fb_err, m_flen == 0);
      end
   end

   task automatic mux_check(input int code, input bit dl, input bit al);
      logic [1:0] e;
      pin_sel = 4'(code); dig_lock = dl; ana_lock = al;
      #2;
      e = exp_pin(code, dl, al, fb_half, ref_half);
      chk(stat_oe == e[1], req_of(code), $sformatf("stat_oe code %0d", code), stat_oe, e[1]);
      chk(stat_pin == e[0], req_of(code), $sformatf("stat_pin code %0d", code), stat_pin, e[0]);
   endtask

   // reference-side stimulus
   initial begin
      int first;
      int seen;
      void'($urandom(32'd20240611));
      rst_n = 0; ref_div = 12'd3; fb_div = 18'd5; pin_sel = 4'd0;
      dig_lock = 0; ana_lock = 0; lock_div4 = 0;
      repeat (3) @(negedge ref_clk);
      // R11: reset state
      chk(!ref_pulse && !fb_pulse, "R11", "pulses in reset", ref_pulse | fb_pulse, 0);
      chk(!ref_half && !fb_half, "R11", "halves in reset", ref_half | fb_half, 0);
      chk(!ref_err && !fb_err && !lock_tick, "R11", "err/tick in reset",
          ref_err | fb_err | lock_tick, 0);
      rst_n = 1;
      // R1: first strobe uses the reset value 10, not the input 3
      first = 0;
      for (int i = 1; i <= 12 && first == 0; i++) begin
         @(negedge ref_clk);
         if (ref_pulse) first = i;
      end
      chk(first == 10, "R1", "edges to first ref strobe", first, 10);
      // R5..R9: full selector sweep against both lock levels
      for (int c = 0; c < 16; c++) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge ref_clk);
            mux_check(c, k[0], k[1]);
         end
      end
      // R4: zero divide value stops the divider
      @(negedge ref_clk); ref_div = 12'd0;
      repeat (20) @(negedge ref_clk);
      chk(ref_err == 1'b1, "R4", "ref_err after zero", ref_err, 1);
      seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge ref_clk);
         if (ref_pulse) seen++;
      end
      chk(seen == 0, "R4", "strobes while stopped", seen, 0);
      ref_div = 12'd7;
      @(negedge ref_clk);
      chk(ref_err == 1'b0, "R4", "ref_err after restart", ref_err, 0);
      first = 0;
      for (int i = 1; i <= 9 && first == 0; i++) begin
         @(negedge ref_clk);
         if (ref_pulse) first = i;
      end
      chk(first == 7, "R4", "edges to strobe after restart", first, 7);
      // R10: divide-by-four option
      ref_div = 12'd1; lock_div4 = 1;
      repeat (40) @(negedge ref_clk);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         @(negedge ref_clk);
         if ($urandom_range(0, 39) == 0)
            ref_div = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(1, 12));
         if ($urandom_range(0, 99) == 0) lock_div4 = ~lock_div4;
         if (i % 8 == 0)
            mux_check(int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)),
                      bit'($urandom_range(0, 1)));
      end
      ref_done = 1;
   end

   // feedback-side stimulus
   initial begin
      @(posedge rst_n);
      // R2: reset value 760 governs the first interval
      for (int i = 0; i < 900; i++) @(negedge fb_clk);
      for (int i = 0; i < 2500; i++) begin
         @(negedge fb_clk);
         if ($urandom_range(0, 29) == 0)
            fb_div = ($urandom_range(0, 7) == 0) ? 18'd0 : 18'($urandom_range(1, 15));
      end
      fb_div = 18'd1;
      repeat (20) @(negedge fb_clk);
      fb_done = 1;
   end

   initial begin
      wait (ref_done && fb_done);
      repeat (2) @(negedge ref_clk);
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge ref_clk);
      nerr++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
   end

endmodule